// File: doc/BRIEF.md
# Triggered Capture Memory Controller

This block runs the write side of two capture buffers that share one trigger. The input buffer holds 2048 words of 32 bits and stores either interpolator I/Q samples, pre-distorter I/Q samples or the pre-distorter magnitude. The feedback buffer holds 1024 words of 20 bits and stores the feedback samples unchanged. Each buffer has a small mode machine that is idle, armed or capturing. It can make a single pass over its buffer or a looping pass that wraps until it is told to stop.

Software arms a buffer by issuing a mode request. The buffer then waits for a trigger from the source that the select picks. The sources are an external pin, a window comparator on the magnitude bus, or a processor trigger write. Only the first trigger after arming starts a capture. Any later trigger is ignored until the buffer has gone back to idle and been armed again. The block drives a write enable, an address and a data word to each buffer RAM on every capture cycle.

Top module: `capture_ctrl`

## Requirements
- R1: After reset both buffers report state idle (code 00) and neither write enable is asserted.
- R2: A mode request to an idle buffer with code 01 (single) or 10 (loop) moves it to armed (state code 01) on the next cycle. Codes 00 and 11 leave it idle. State code 10 means capturing, and code 11 never appears.
- R3: The trigger select uses code 00 for the processor trigger, 01 for the external pin and 10 for the magnitude window. Code 11 selects no source. trig_o shows the selected trigger event in the same cycle.
- R4: The window trigger fires in any cycle where win_lo_i <= mag_i <= win_hi_i, as unsigned values with both bounds inclusive.
- R5: The processor trigger fires in a cycle where proc_trig_wr_i is high and proc_trig_bit_i is 1. When the select is not 00 it has no effect.
- R6: An armed buffer that sees a trigger is capturing on the next cycle. It writes address 0 first and then one increasing address per cycle, with the write enable high.
- R7: A trigger that arrives while a buffer is idle or already capturing has no effect on its state or address sequence.
- R8: In single mode, after the write to the last address, the buffer returns to idle on the next cycle.
- R9: In loop mode the address wraps from the last entry to 0. A mode request with code 00 sends the buffer to idle on the next cycle, whether it is armed or capturing.
- R10: While a buffer is armed or capturing, every mode request is ignored, except the code 00 request in loop mode.
- R11: Both buffers act on the same trigger event in the same cycle.
- R12: With source select 00 (interpolator) or 01 (pre-distorter) and rounding off, the word is {I[19:4], Q[19:4]}. Source select 11 gives a zero word.
- R13: With rounding on, each 16-bit half gets bit 3 of its sample added before truncation. It saturates to 0x7FFF when that addition would overflow the positive range.
- R14: Source select 10 stores magnitude bit 15 as bit 16 of the word and bits 14:0 as bits 14:0, with all other bits 0. Feedback words are the 20-bit feedback sample unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_mode_wr_i | input | 1 | Mode request strobe, input buffer |
| in_mode_req_i | input | 2 | Requested mode, input buffer |
| fb_mode_wr_i | input | 1 | Mode request strobe, feedback buffer |
| fb_mode_req_i | input | 2 | Requested mode, feedback buffer |
| trig_sel_i | input | 2 | Trigger source select |
| ext_trig_i | input | 1 | External trigger pin |
| proc_trig_wr_i | input | 1 | Write strobe for the processor trigger bit |
| proc_trig_bit_i | input | 1 | Value written to the processor trigger bit |
| mag_i | input | 16 | Pre-distorter magnitude |
| win_lo_i | input | 16 | Window lower bound |
| win_hi_i | input | 16 | Window upper bound |
| in_src_sel_i | input | 2 | Input buffer data source |
| round_en_i | input | 1 | Round I/Q to 16 bits |
| interp_i_i | input | 20 | Interpolator I sample |
| interp_q_i | input | 20 | Interpolator Q sample |
| pd_i_i | input | 20 | Pre-distorter I sample |
| pd_q_i | input | 20 | Pre-distorter Q sample |
| fb_sample_i | input | 20 | Feedback sample |
| trig_o | output | 1 | Selected trigger event |
| in_state_o | output | 2 | Input buffer state |
| in_we_o | output | 1 | Input buffer write enable |
| in_addr_o | output | 11 | Input buffer write address |
| in_data_o | output | 32 | Input buffer write data |
| fb_state_o | output | 2 | Feedback buffer state |
| fb_we_o | output | 1 | Feedback buffer write enable |
| fb_addr_o | output | 10 | Feedback buffer write address |
| fb_data_o | output | 20 | Feedback buffer write data |

## Verification
A wrong mode state shows up at the state and write-enable ports one cycle after the triggering or requesting edge. Examples are an accepted second trigger, an ignored loop cancel or a missed wrap. A wrong address step shows up on the very next write. A fault in packing or rounding shows up in the data word during the same capture cycle. The saturation and wrap corners only appear at particular sample values and at the last buffer address, so these are driven on purpose. Every output is compared against a behavioural model on every clock.

// File: rtl/capmem_pkg.sv
package capmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_CAPT  = 2'b10
  } cap_state_e;

  localparam logic [1:0] MODE_IDLE   = 2'b00;
  localparam logic [1:0] MODE_SINGLE = 2'b01;
  localparam logic [1:0] MODE_LOOP   = 2'b10;

  localparam logic [1:0] TSEL_PROC = 2'b00;
  localparam logic [1:0] TSEL_EXT  = 2'b01;
  localparam logic [1:0] TSEL_WIN  = 2'b10;

  localparam logic [1:0] SRC_INTERP = 2'b00;
  localparam logic [1:0] SRC_PD     = 2'b01;
  localparam logic [1:0] SRC_MAG    = 2'b10;
endpackage

// File: rtl/capmem_trig.sv
module capmem_trig
  import capmem_pkg::*;
#(
  parameter int MAG_W = 16
) (
  input  logic [1:0]       sel_i,
  input  logic             ext_i,
  input  logic             proc_wr_i,
  input  logic             proc_bit_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [MAG_W-1:0] lo_i,
  input  logic [MAG_W-1:0] hi_i,
  output logic             trig_o
);
  logic in_window;
  logic proc_fire;

  assign in_window = (mag_i >= lo_i) && (mag_i <= hi_i);
  // any write that carries the trigger value fires
  assign proc_fire = proc_wr_i && proc_bit_i;

  always_comb begin
    unique case (sel_i)
      TSEL_PROC: trig_o = proc_fire;
      TSEL_EXT:  trig_o = ext_i;
      TSEL_WIN:  trig_o = in_window;
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/capmem_seq.sv
module capmem_seq
  import capmem_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [1:0]    mode_req_i,
  input  logic          trig_i,
  output logic [1:0]    state_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    st_q;
  logic          loop_q;
  logic [AW-1:0] addr_q;
  logic          cancel;
  logic          arm_req;

  // only loop mode honours an idle request mid-sequence
  assign cancel  = loop_q && mode_wr_i && (mode_req_i == MODE_IDLE);
  assign arm_req = mode_wr_i && ((mode_req_i == MODE_SINGLE) || (mode_req_i == MODE_LOOP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      loop_q <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (arm_req) begin
            st_q   <= ST_ARMED;
            loop_q <= (mode_req_i == MODE_LOOP);
          end
        end
        ST_ARMED: begin
          if (cancel) begin
            st_q <= ST_IDLE;
          end else if (trig_i) begin
            st_q   <= ST_CAPT;
            addr_q <= '0;
          end
        end
        ST_CAPT: begin
          if (cancel) begin
            st_q <= ST_IDLE;
          end else if (addr_q == LAST) begin
            if (loop_q) addr_q <= '0;
            else        st_q   <= ST_IDLE;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign we_o    = (st_q == ST_CAPT);
  assign addr_o  = addr_q;
endmodule

// File: rtl/capmem_pack.sv
module capmem_pack
  import capmem_pkg::*;
#(
  parameter int SMP_W  = 20,
  parameter int WORD_W = 16,
  parameter int MAG_W  = 16,
  localparam int DW    = 2 * WORD_W,
  localparam int NLANE = 4
) (
  input  logic [1:0]       src_sel_i,
  input  logic             round_en_i,
  input  logic [SMP_W-1:0] a_i_i,
  input  logic [SMP_W-1:0] a_q_i,
  input  logic [SMP_W-1:0] b_i_i,
  input  logic [SMP_W-1:0] b_q_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [DW-1:0]    data_o
);
  logic [SMP_W-1:0]  lane_in  [NLANE];
  logic [WORD_W-1:0] lane_out [NLANE];
  logic [DW-1:0]     mag_word;

  assign lane_in[0] = a_i_i;
  assign lane_in[1] = a_q_i;
  assign lane_in[2] = b_i_i;
  assign lane_in[3] = b_q_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [WORD_W-1:0] top_w;
    logic [WORD_W:0]   sum_w;
    logic              half;
    assign top_w = lane_in[g][SMP_W-1 -: WORD_W];
    assign half  = round_en_i & lane_in[g][SMP_W-WORD_W-1];
    assign sum_w = {top_w[WORD_W-1], top_w} + {{WORD_W{1'b0}}, half};
    // positive overflow clamps to max
    assign lane_out[g] = (!top_w[WORD_W-1] && sum_w[WORD_W-1]) ?
                         {1'b0, {(WORD_W-1){1'b1}}} : sum_w[WORD_W-1:0];
  end

  assign mag_word = {{(WORD_W-1){1'b0}}, mag_i[MAG_W-1],
                     {(WORD_W-MAG_W+1){1'b0}}, mag_i[MAG_W-2:0]};

  always_comb begin
    unique case (src_sel_i)
      SRC_INTERP: data_o = {lane_out[0], lane_out[1]};
      SRC_PD:     data_o = {lane_out[2], lane_out[3]};
      SRC_MAG:    data_o = mag_word;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capmem_pkg::*;
#(
  parameter int IN_DEPTH = 2048,
  parameter int FB_DEPTH = 1024,
  parameter int SMP_W    = 20,
  parameter int WORD_W   = 16,
  parameter int MAG_W    = 16,
  parameter int FB_W     = 20,
  localparam int IN_AW   = $clog2(IN_DEPTH),
  localparam int FB_AW   = $clog2(FB_DEPTH),
  localparam int IN_DW   = 2 * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_mode_wr_i,
  input  logic [1:0]       in_mode_req_i,
  input  logic             fb_mode_wr_i,
  input  logic [1:0]       fb_mode_req_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             ext_trig_i,
  input  logic             proc_trig_wr_i,
  input  logic             proc_trig_bit_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [MAG_W-1:0] win_lo_i,
  input  logic [MAG_W-1:0] win_hi_i,
  input  logic [1:0]       in_src_sel_i,
  input  logic             round_en_i,
  input  logic [SMP_W-1:0] interp_i_i,
  input  logic [SMP_W-1:0] interp_q_i,
  input  logic [SMP_W-1:0] pd_i_i,
  input  logic [SMP_W-1:0] pd_q_i,
  input  logic [FB_W-1:0]  fb_sample_i,
  output logic             trig_o,
  output logic [1:0]       in_state_o,
  output logic             in_we_o,
  output logic [IN_AW-1:0] in_addr_o,
  output logic [IN_DW-1:0] in_data_o,
  output logic [1:0]       fb_state_o,
  output logic             fb_we_o,
  output logic [FB_AW-1:0] fb_addr_o,
  output logic [FB_W-1:0]  fb_data_o
);
  logic trig;

  capmem_trig #(.MAG_W(MAG_W)) u_trig (
    .sel_i      (trig_sel_i),
    .ext_i      (ext_trig_i),
    .proc_wr_i  (proc_trig_wr_i),
    .proc_bit_i (proc_trig_bit_i),
    .mag_i      (mag_i),
    .lo_i       (win_lo_i),
    .hi_i       (win_hi_i),
    .trig_o     (trig)
  );

  capmem_seq #(.DEPTH(IN_DEPTH)) u_in_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (in_mode_wr_i),
    .mode_req_i (in_mode_req_i),
    .trig_i     (trig),
    .state_o    (in_state_o),
    .we_o       (in_we_o),
    .addr_o     (in_addr_o)
  );

  capmem_seq #(.DEPTH(FB_DEPTH)) u_fb_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (fb_mode_wr_i),
    .mode_req_i (fb_mode_req_i),
    .trig_i     (trig),
    .state_o    (fb_state_o),
    .we_o       (fb_we_o),
    .addr_o     (fb_addr_o)
  );

  capmem_pack #(.SMP_W(SMP_W), .WORD_W(WORD_W), .MAG_W(MAG_W)) u_pack (
    .src_sel_i  (in_src_sel_i),
    .round_en_i (round_en_i),
    .a_i_i      (interp_i_i),
    .a_q_i      (interp_q_i),
    .b_i_i      (pd_i_i),
    .b_q_i      (pd_q_i),
    .mag_i      (mag_i),
    .data_o     (in_data_o)
  );

  assign trig_o    = trig;
  assign fb_data_o = fb_sample_i;
endmodule

// File: rtl/capture_ctrl_chk.sv
module capture_ctrl_chk #(
  parameter int IN_DEPTH = 2048,
  parameter int FB_DEPTH = 1024,
  parameter int MAG_W    = 16,
  localparam int IN_AW   = $clog2(IN_DEPTH),
  localparam int FB_AW   = $clog2(FB_DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_mode_wr_i,
  input logic [1:0]       in_mode_req_i,
  input logic             fb_mode_wr_i,
  input logic [1:0]       fb_mode_req_i,
  input logic [1:0]       trig_sel_i,
  input logic             ext_trig_i,
  input logic [MAG_W-1:0] mag_i,
  input logic [MAG_W-1:0] win_lo_i,
  input logic [MAG_W-1:0] win_hi_i,
  input logic [1:0]       in_src_sel_i,
  input logic             trig_o,
  input logic [1:0]       in_state_o,
  input logic [IN_AW-1:0] in_addr_o,
  input logic [31:0]      in_data_o,
  input logic [1:0]       fb_state_o
);
  localparam logic [IN_AW-1:0] IN_LAST = IN_AW'(IN_DEPTH - 1);

  logic in_idle_req, fb_idle_req, in_arm_req;
  assign in_idle_req = in_mode_wr_i && (in_mode_req_i == 2'b00);
  assign fb_idle_req = fb_mode_wr_i && (fb_mode_req_i == 2'b00);
  assign in_arm_req  = in_mode_wr_i && (in_mode_req_i == 2'b01 || in_mode_req_i == 2'b10);

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state_o != 2'b11) && (fb_state_o != 2'b11)); // R2

  AST_ARM_TO_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state_o == 2'b01 && trig_o && !in_idle_req) |=> (in_state_o == 2'b10 && in_addr_o == '0)); // R6

  AST_SHARED_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_state_o == 2'b01 && trig_o && !fb_idle_req) |=> (fb_state_o == 2'b10)); // R11

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state_o == 2'b10 && in_addr_o != IN_LAST && !in_idle_req)
      |=> (in_state_o == 2'b10 && in_addr_o == $past(in_addr_o) + 1'b1)); // R7

  AST_LAST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state_o == 2'b10 && in_addr_o == IN_LAST)
      |=> (in_state_o == 2'b00 || (in_state_o == 2'b10 && in_addr_o == '0))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state_o == 2'b00 && !in_arm_req) |=> (in_state_o == 2'b00)); // R2

  AST_EXT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'b01) |-> (trig_o == ext_trig_i)); // R3

  AST_NO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'b11) |-> !trig_o); // R3

  AST_WIN_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'b10 && (mag_i < win_lo_i || mag_i > win_hi_i)) |-> !trig_o); // R4

  AST_MAG_PACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_src_sel_i == 2'b10) |-> (in_data_o[31:17] == '0 && in_data_o[15] == 1'b0)); // R14
endmodule

bind capture_ctrl capture_ctrl_chk #(
  .IN_DEPTH (IN_DEPTH),
  .FB_DEPTH (FB_DEPTH),
  .MAG_W    (MAG_W)
) u_chk (.*);

// File: tb/capture_ctrl_bench.sv
`timescale 1ns/1ps
module capture_ctrl_bench;
  localparam int IN_DEPTH = 2048;
  localparam int FB_DEPTH = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_mode_wr = 0, fb_mode_wr = 0;
  logic [1:0]  in_mode_req = 0, fb_mode_req = 0;
  logic [1:0]  trig_sel = 0;
  logic        ext_trig = 0, proc_wr = 0, proc_bit = 0;
  logic [15:0] mag = 0, win_lo = 0, win_hi = 0;
  logic [1:0]  src_sel = 0;
  logic        round_en = 0;
  logic [19:0] ii = 0, iq = 0, pi = 0, pq = 0, fbs = 0;

  logic        trig_o, in_we, fb_we;
  logic [1:0]  in_st, fb_st;
  logic [10:0] in_addr;
  logic [9:0]  fb_addr;
  logic [31:0] in_data;
  logic [19:0] fb_data;

  capture_ctrl u_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .in_mode_wr_i(in_mode_wr), .in_mode_req_i(in_mode_req),
    .fb_mode_wr_i(fb_mode_wr), .fb_mode_req_i(fb_mode_req),
    .trig_sel_i(trig_sel), .ext_trig_i(ext_trig),
    .proc_trig_wr_i(proc_wr), .proc_trig_bit_i(proc_bit),
    .mag_i(mag), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .in_src_sel_i(src_sel), .round_en_i(round_en),
    .interp_i_i(ii), .interp_q_i(iq), .pd_i_i(pi), .pd_q_i(pq),
    .fb_sample_i(fbs),
    .trig_o(trig_o), .in_state_o(in_st), .in_we_o(in_we), .in_addr_o(in_addr),
    .in_data_o(in_data), .fb_state_o(fb_st), .fb_we_o(fb_we), .fb_addr_o(fb_addr),
    .fb_data_o(fb_data)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, data_rand = 1;
  string cur_tag = "R1";

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int m_in_st = 0, m_in_lp = 0, m_in_ad = 0;
  int m_fb_st = 0, m_fb_lp = 0, m_fb_ad = 0;

  function automatic bit m_trig();
    case (trig_sel)
      2'd0: return proc_wr && proc_bit;
      2'd1: return ext_trig;
      2'd2: return (int'(mag) >= int'(win_lo)) && (int'(mag) <= int'(win_hi));
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] m_narrow(logic [19:0] v, bit rnd);
    int s, q;
    s = $signed(v);
    q = rnd ? ((s + 8) >>> 4) : (s >>> 4);
    if (q > 32767) q = 32767;
    return q[15:0];
  endfunction

  function automatic logic [31:0] m_word();
    case (src_sel)
      2'd0: return {m_narrow(ii, round_en), m_narrow(iq, round_en)};
      2'd1: return {m_narrow(pi, round_en), m_narrow(pq, round_en)};
      2'd2: return {15'd0, mag[15], 1'b0, mag[14:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_step(ref int st, ref int lp, ref int ad, input bit wr, input int req,
                        input bit t, input int depth);
    bit stop;
    stop = (lp != 0) && wr && (req == 0);
    if (st == 0) begin
      if (wr && (req == 1 || req == 2)) begin st = 1; lp = (req == 2); end
    end else if (stop) begin
      st = 0;
    end else if (st == 1) begin
      if (t) begin st = 2; ad = 0; end
    end else begin
      if (ad == depth - 1) begin
        if (lp != 0) ad = 0; else st = 0;
      end else ad = ad + 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in_st = 0; m_in_lp = 0; m_in_ad = 0;
      m_fb_st = 0; m_fb_lp = 0; m_fb_ad = 0;
    end else begin
      bit t;
      t = m_trig();
      m_step(m_in_st, m_in_lp, m_in_ad, in_mode_wr, int'(in_mode_req), t, IN_DEPTH);
      m_step(m_fb_st, m_fb_lp, m_fb_ad, fb_mode_wr, int'(fb_mode_req), t, FB_DEPTH);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string dtag;
      dtag = (src_sel == 2'd2) ? "R14" : (round_en ? "R13" : "R12");
      check(trig_o == m_trig(), "R3", "trig_o", 32'(trig_o), 32'(m_trig()));
      check(in_st == 2'(m_in_st), cur_tag, "in_state", 32'(in_st), 32'(m_in_st));
      check(in_we == (m_in_st == 2), cur_tag, "in_we", 32'(in_we), 32'(m_in_st == 2));
      check(fb_st == 2'(m_fb_st), cur_tag, "fb_state", 32'(fb_st), 32'(m_fb_st));
      check(fb_we == (m_fb_st == 2), cur_tag, "fb_we", 32'(fb_we), 32'(m_fb_st == 2));
      if (m_in_st == 2) begin
        check(in_addr == 11'(m_in_ad), cur_tag, "in_addr", 32'(in_addr), 32'(m_in_ad));
        check(in_data == m_word(), dtag, "in_data", in_data, m_word());
      end
      if (m_fb_st == 2) begin
        check(fb_addr == 10'(m_fb_ad), cur_tag, "fb_addr", 32'(fb_addr), 32'(m_fb_ad));
        check(fb_data == fbs, "R14", "fb_data", 32'(fb_data), 32'(fbs));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (data_rand) begin
      ii = 20'($urandom); iq = 20'($urandom);
      pi = 20'($urandom); pq = 20'($urandom);
      round_en = 1'($urandom);
    end
    fbs = 20'($urandom);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic mode(bit to_in, bit to_fb, logic [1:0] m);
    in_mode_wr = to_in; fb_mode_wr = to_fb; in_mode_req = m; fb_mode_req = m;
    tick();
    in_mode_wr = 0; fb_mode_wr = 0;
  endtask

  task automatic ptrig(bit b);
    proc_wr = 1; proc_bit = b; tick(); proc_wr = 0; proc_bit = 0;
  endtask

  task automatic etrig();
    ext_trig = 1; tick(); ext_trig = 0;
  endtask

  initial begin
    tick(3);
    @(negedge clk);
    check(in_st == 2'b00 && fb_st == 2'b00, "R1", "reset state", 32'({in_st, fb_st}), 0);
    check(!in_we && !fb_we, "R1", "reset we", 32'({in_we, fb_we}), 0);
    @(posedge clk); #2; rst_n = 1;
    tick(2);

    cur_tag = "R2";
    mode(1, 1, 2'b00); mode(1, 1, 2'b11); tick(2);
    mode(1, 1, 2'b01); tick(2);
    cur_tag = "R5";
    trig_sel = 2'b01; ptrig(1); tick();
    trig_sel = 2'b00; ptrig(0); tick(2);
    cur_tag = "R10";
    mode(1, 1, 2'b10); mode(1, 1, 2'b00); tick(2);
    cur_tag = "R6";
    ptrig(1); tick(5);
    cur_tag = "R7";
    ptrig(1); trig_sel = 2'b01; etrig(); tick(3); trig_sel = 2'b00;
    cur_tag = "R10";
    mode(1, 1, 2'b00); mode(1, 1, 2'b10); tick(10);
    cur_tag = "R8";
    tick(2100);
    cur_tag = "R7";
    etrig(); ptrig(1); tick(3);

    cur_tag = "R4";
    trig_sel = 2'b10; win_lo = 16'h1000; win_hi = 16'h2000;
    mag = 16'h0FFF;
    mode(1, 0, 2'b10); mode(0, 1, 2'b01); tick(2);
    mag = 16'h2001; tick(2);
    mag = 16'h2000; tick();
    mag = 16'h1000; tick();
    cur_tag = "R9";
    src_sel = 2'b10;
    repeat (2200) begin mag = 16'($urandom); tick(); end
    mode(1, 0, 2'b00); tick(3);
    mag = 16'h0500;
    mode(1, 0, 2'b10); tick(2);
    mode(1, 0, 2'b00); tick(3);

    cur_tag = "R11";
    trig_sel = 2'b01; src_sel = 2'b01;
    mode(1, 0, 2'b01); mode(0, 1, 2'b10); tick(2);
    etrig(); tick(500);
    src_sel = 2'b11; tick(20);
    src_sel = 2'b10;
    repeat (20) begin mag = 16'($urandom); tick(); end
    src_sel = 2'b00; tick(1700);
    cur_tag = "R9";
    tick(300);
    mode(0, 1, 2'b00); tick(3);

    cur_tag = "R13";
    data_rand = 0; src_sel = 2'b00;
    mode(1, 0, 2'b01); tick(); etrig(); tick(2);
    ii = 20'h7FFF8; iq = 20'h80007; round_en = 1; tick();
    @(negedge clk);
    check(in_data == 32'h7FFF_8000, "R13", "saturate/neg", in_data, 32'h7FFF_8000);
    @(posedge clk); #2;
    ii = 20'hFFFF8; iq = 20'h00018; tick();
    @(negedge clk);
    check(in_data == 32'h0000_0002, "R13", "round up", in_data, 32'h0000_0002);
    @(posedge clk); #2;
    round_en = 0; tick();
    @(negedge clk);
    check(in_data == 32'hFFFF_0001, "R12", "truncate", in_data, 32'hFFFF_0001);
    @(posedge clk); #2;
    src_sel = 2'b10; mag = 16'h8123; tick();
    @(negedge clk);
    check(in_data == 32'h0001_0123, "R14", "mag pack", in_data, 32'h0001_0123);
    @(posedge clk); #2;
    data_rand = 1;
    tick(2100);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule